// File: doc/BRIEF.md
# Bus Timeout Error Generator

This block sits in the interconnect path between one pipelined Wishbone master and one slave. It forwards the request and response signals in both directions. It also watches each bus cycle for two kinds of hang. The first is a slave that holds off a pending strobe for too long. The second is a slave that leaves an accepted request without an acknowledgement for too long. When either limit expires, the block answers the master with a bus error in place of the slave.

An error is sticky. ERR and STALL are both held toward the master until the master lowers CYC. While the error is held, no new strobe reaches the slave and no slave acknowledgement reaches the master.

A falling CYC ends the cycle, and the block treats it as an abort of every request still open. The block keeps a running count of open requests (accepted minus acknowledged), and that count is cleared whenever CYC is low. As a result, a registered acknowledgement that the slave returns after the abort is discarded, including when the master raises CYC again on the very next clock. The two limits are parameters: `MAX_STALL` and `MAX_ACK_WAIT`.

Top module: `bus_timeout_guard`

## Requirements
- R1: After a synchronous reset, `m_err` and `m_ack` are low, and `m_stall` equals `s_stall`.
- R2: While no error is held, `s_cyc` equals `m_cyc`. Address, write enable, write data and byte selects pass through unchanged. `m_rdata` always equals `s_rdata`.
- R3: The stall limit counts clock edges on which `m_cyc`, `m_stb` and `s_stall` are all high and no error is held. After `MAX_STALL` such edges in a row, `m_err` is high following the last of them. Any edge that breaks the run resets the count.
- R4: The acknowledge limit counts clock edges on which CYC is high, at least one request is open, no error is held and `s_ack` is low. After `MAX_ACK_WAIT` such edges in a row, `m_err` is high following the last of them. A request is accepted on an edge where `s_stb` is high and `s_stall` is low.
- R5: `m_ack` equals `s_ack` only when `m_cyc` is high, no error is held, and at least one request accepted on an earlier edge of this cycle has not yet been acknowledged. In every other case `m_ack` is low.
- R6: Once `m_err` is high, it stays high on every clock while `m_cyc` stays high. It goes low in the same clock that `m_cyc` goes low.
- R7: Whenever `m_err` is high, `m_stall` is high, whatever `s_stall` is.
- R8: While the error is held, `s_stb` is low. Otherwise `s_stb` equals `m_stb` AND `m_cyc`.
- R9: A slave acknowledgement that arrives in the clock after CYC fell is not forwarded.
- R10: `m_ack` and `m_err` are never high in the same clock.
- R11: The open-request count is cleared while CYC is low. In a new cycle with no accepted request, a late `s_ack` is not forwarded and no acknowledge timeout occurs.
- R12: A forwarded acknowledgement restarts the acknowledge limit. If requests remain open, a full `MAX_ACK_WAIT` window applies again from that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_cyc | input | 1 | Cycle line from the master |
| m_stb | input | 1 | Request strobe from the master |
| m_we | input | 1 | Write enable from the master |
| m_addr | input | ADDR_W | Request address from the master |
| m_wdata | input | DATA_W | Write data from the master |
| m_sel | input | SEL_W | Byte selects from the master |
| m_stall | output | 1 | Stall toward the master |
| m_ack | output | 1 | Forwarded acknowledgement toward the master |
| m_err | output | 1 | Timeout error toward the master |
| m_rdata | output | DATA_W | Read data toward the master |
| s_cyc | output | 1 | Cycle line toward the slave |
| s_stb | output | 1 | Gated strobe toward the slave |
| s_we | output | 1 | Write enable toward the slave |
| s_addr | output | ADDR_W | Address toward the slave |
| s_wdata | output | DATA_W | Write data toward the slave |
| s_sel | output | SEL_W | Byte selects toward the slave |
| s_stall | input | 1 | Stall from the slave |
| s_ack | input | 1 | Acknowledgement from the slave |
| s_rdata | input | DATA_W | Read data from the slave |

## Verification
The stall limit and the acknowledge limit can expire on the same clock edge. The bench provokes this with a directed sequence. It accepts one request, leaves it unacknowledged, and then stalls a new strobe so that the last of the `MAX_STALL` stalled edges coincides with edge `MAX_ACK_WAIT` of the acknowledge wait. The outcome is judged as follows: `m_err` must stay low through that edge and rise exactly after it. After that, the single error must behave like any other, with STALL held, the strobe gated and acknowledgements blocked. A randomized phase then mixes aborts, stalls and sparse acknowledgements against a cycle model built from the requirements.

// File: rtl/bto_pkg.sv
package bto_pkg;

    typedef struct packed {
        logic hold;     // error presented to master
        logic fwd_stb;  // strobe allowed toward slave
        logic fwd_ack;  // slave ack allowed toward master
        logic stall;    // stall presented to master
    } guard_ctl_t;

    function automatic guard_ctl_t guard_ctl(
        input logic err_q,
        input logic cyc,
        input logic stb,
        input logic open_nz,
        input logic sl_ack,
        input logic sl_stall
    );
        guard_ctl_t c;
        c.hold    = err_q & cyc;
        c.fwd_stb = stb & cyc & ~err_q;
        c.fwd_ack = sl_ack & cyc & ~err_q & open_nz;
        c.stall   = err_q | sl_stall;
        return c;
    endfunction

    function automatic int unsigned limit_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/bto_timeout_ctr.sv
module bto_timeout_ctr
    import bto_pkg::*;
#(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic fire
);
    localparam int unsigned CW = limit_width(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // expires on the edge that completes LIMIT consecutive run edges
    assign fire = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr || !run || fire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/bto_open_ctr.sv
module bto_open_ctr #(
    parameter int unsigned W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] count,
    output logic         nonzero
);
    logic [W-1:0] cnt_q;

    assign count   = cnt_q;
    assign nonzero = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/bus_timeout_guard.sv
module bus_timeout_guard
    import bto_pkg::*;
#(
    parameter int unsigned ADDR_W       = 30,
    parameter int unsigned DATA_W       = 32,
    parameter int unsigned SEL_W        = DATA_W / 8,
    parameter int unsigned MAX_STALL    = 16,
    parameter int unsigned MAX_ACK_WAIT = 256,
    parameter int unsigned OPEN_W       = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              m_cyc,
    input  logic              m_stb,
    input  logic              m_we,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic [DATA_W-1:0] m_wdata,
    input  logic [SEL_W-1:0]  m_sel,
    output logic              m_stall,
    output logic              m_ack,
    output logic              m_err,
    output logic [DATA_W-1:0] m_rdata,
    output logic              s_cyc,
    output logic              s_stb,
    output logic              s_we,
    output logic [ADDR_W-1:0] s_addr,
    output logic [DATA_W-1:0] s_wdata,
    output logic [SEL_W-1:0]  s_sel,
    input  logic              s_stall,
    input  logic              s_ack,
    input  logic [DATA_W-1:0] s_rdata
);
    logic              err_q;
    logic              open_nz;
    logic [OPEN_W-1:0] open_cnt;
    logic              stall_fire;
    logic              ack_fire;
    logic              accepted;
    guard_ctl_t        ctl;

    assign ctl      = guard_ctl(err_q, m_cyc, m_stb, open_nz, s_ack, s_stall);
    assign accepted = ctl.fwd_stb & ~s_stall;

    // request path
    assign s_cyc   = m_cyc;
    assign s_stb   = ctl.fwd_stb;
    assign s_we    = m_we;
    assign s_addr  = m_addr;
    assign s_wdata = m_wdata;
    assign s_sel   = m_sel;

    // response path
    assign m_stall = ctl.stall;
    assign m_ack   = ctl.fwd_ack;
    assign m_err   = ctl.hold;
    assign m_rdata = s_rdata;

    bto_open_ctr #(.W(OPEN_W)) u_open (
        .clk     (clk),
        .rst     (rst),
        .clr     (~m_cyc),
        .inc     (accepted),
        .dec     (ctl.fwd_ack),
        .count   (open_cnt),
        .nonzero (open_nz)
    );

    bto_timeout_ctr #(.LIMIT(MAX_STALL)) u_stall_tmr (
        .clk  (clk),
        .rst  (rst),
        .clr  (~m_cyc),
        .run  (ctl.fwd_stb & s_stall),
        .fire (stall_fire)
    );

    bto_timeout_ctr #(.LIMIT(MAX_ACK_WAIT)) u_ack_tmr (
        .clk  (clk),
        .rst  (rst),
        .clr  (~m_cyc),
        .run  (m_cyc & ~err_q & open_nz & ~s_ack),
        .fire (ack_fire)
    );

    always_ff @(posedge clk) begin
        if (rst || !m_cyc) begin
            err_q <= 1'b0;
        end else if (stall_fire || ack_fire) begin
            err_q <= 1'b1;
        end
    end

    logic unused_ok;
    assign unused_ok = ^open_cnt;
endmodule

// File: rtl/bto_guard_chk.sv
module bto_guard_chk #(
    parameter int unsigned MAX_STALL = 16
) (
    input logic clk,
    input logic rst,
    input logic m_cyc,
    input logic m_stb,
    input logic m_stall,
    input logic m_ack,
    input logic m_err,
    input logic s_stb,
    input logic s_stall
);
    localparam int unsigned RW = $clog2(MAX_STALL + 2);
    logic [RW-1:0] stall_run;

    always_ff @(posedge clk) begin
        if (rst || !(m_cyc && m_stb && s_stall && !m_err)) begin
            stall_run <= '0;
        end else if (stall_run != RW'(MAX_STALL)) begin
            stall_run <= stall_run + 1'b1;
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (m_err && m_cyc) |=> (m_err || !m_cyc));            // R6
    AST_ERR_WITH_STALL: assert property (@(posedge clk) disable iff (rst)
        m_err |-> m_stall);                                  // R7
    AST_STB_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        m_err |-> !s_stb);                                   // R8
    AST_NO_LATE_ACK: assert property (@(posedge clk) disable iff (rst)
        !m_cyc |=> !m_ack);                                  // R9
    AST_ACK_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(m_ack && m_err));                                  // R10
    AST_STALL_BOUND: assert property (@(posedge clk) disable iff (rst)
        (stall_run == RW'(MAX_STALL) && m_cyc) |-> m_err);   // R3
endmodule

bind bus_timeout_guard bto_guard_chk #(.MAX_STALL(MAX_STALL)) u_guard_chk (
    .clk     (clk),
    .rst     (rst),
    .m_cyc   (m_cyc),
    .m_stb   (m_stb),
    .m_stall (m_stall),
    .m_ack   (m_ack),
    .m_err   (m_err),
    .s_stb   (s_stb),
    .s_stall (s_stall)
);

// File: tb/bus_timeout_guard_tb_top.sv
`timescale 1ns/1ps
module bus_timeout_guard_tb_top;
    localparam int MS = 6;
    localparam int MA = 10;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int SW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_cyc = 0, m_stb = 0, m_we = 0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_wdata = '0;
    logic [SW-1:0] m_sel = '0;
    logic m_stall, m_ack, m_err;
    logic [DW-1:0] m_rdata;
    logic s_cyc, s_stb, s_we;
    logic [AW-1:0] s_addr;
    logic [DW-1:0] s_wdata;
    logic [SW-1:0] s_sel;
    logic s_stall = 0, s_ack = 0;
    logic [DW-1:0] s_rdata = '0;

    always #4 clk = ~clk;

    bus_timeout_guard #(
        .ADDR_W(AW), .DATA_W(DW), .SEL_W(SW),
        .MAX_STALL(MS), .MAX_ACK_WAIT(MA), .OPEN_W(5)
    ) dut_i (.*);

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    // reference state built from the requirements
    bit mo_err;
    int mo_open, mo_sc, mo_ac;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit e_ack(bit cyc, bit sak);
        return sak && cyc && !mo_err && (mo_open != 0);
    endfunction

    function automatic bit e_stb(bit cyc, bit stb);
        return stb && cyc && !mo_err;
    endfunction

    task automatic model_reset();
        mo_err = 0; mo_open = 0; mo_sc = 0; mo_ac = 0;
    endtask

    task automatic step(input bit cyc, input bit stb, input bit sst, input bit sak);
        bit ea, es, fire;
        @(negedge clk);
        m_cyc = cyc; m_stb = stb; s_stall = sst; s_ack = sak;
        m_we = 1'($urandom); m_addr = AW'($urandom); m_wdata = $urandom;
        m_sel = SW'($urandom); s_rdata = $urandom;
        #1;
        ea = e_ack(cyc, sak);
        es = e_stb(cyc, stb);
        check("R6 m_err", m_err, mo_err && cyc);
        check("R7 m_stall", m_stall, mo_err || sst);
        check("R5 m_ack", m_ack, ea);
        check("R8 s_stb", s_stb, es);
        check("R2 m_rdata", m_rdata, s_rdata);
        // advance model to the coming edge
        if (!cyc) begin
            model_reset();
        end else begin
            fire = 0;
            if (stb && sst && !mo_err) begin
                if (mo_sc == MS - 1) begin fire = 1; mo_sc = 0; end else mo_sc++;
            end else mo_sc = 0;
            if (mo_open != 0 && !sak && !mo_err) begin
                if (mo_ac == MA - 1) begin fire = 1; mo_ac = 0; end else mo_ac++;
            end else mo_ac = 0;
            mo_open = mo_open + ((es && !sst) ? 1 : 0) - (ea ? 1 : 0);
            if (fire) mo_err = 1;
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        bit rc;
        void'($urandom(32'd7351));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        check("R1 m_err after reset", m_err, 0);
        check("R1 m_ack after reset", m_ack, 0);
        check("R1 m_stall after reset", m_stall, s_stall);

        // R2 pass-through, one accepted request then its ack (R5)
        step(1, 1, 0, 0);
        check("R2 s_cyc", s_cyc, 1);
        check("R2 s_addr", s_addr, m_addr);
        check("R2 s_we", s_we, m_we);
        check("R2 s_wdata", s_wdata, m_wdata);
        check("R2 s_sel", s_sel, m_sel);
        check("R5 same-clock ack blocked", m_ack, 0);
        step(1, 0, 0, 1);
        check("R5 ack forwarded", m_ack, 1);
        step(0, 0, 0, 0);

        // R3 stall timeout, then hold behaviour
        for (int k = 1; k <= MS; k++) begin
            step(1, 1, 1, 0);
            check("R3 no error before limit", m_err, 0);
        end
        step(1, 1, 1, 0);
        check("R3 error after stall limit", m_err, 1);
        check("R8 strobe gated", s_stb, 0);
        step(1, 1, 0, 1);
        check("R7 stall held", m_stall, 1);
        check("R10 ack blocked under error", m_ack, 0);
        check("R6 error held", m_err, 1);
        step(0, 0, 0, 0);
        check("R6 error drops with cyc", m_err, 0);

        // R4 acknowledge timeout
        step(1, 1, 0, 0);
        for (int j = 1; j <= MA; j++) begin
            step(1, 0, 0, 0);
            check("R4 no error before limit", m_err, 0);
        end
        step(1, 0, 0, 0);
        check("R4 error after ack limit", m_err, 1);
        step(0, 0, 0, 0);

        // R12 ack restarts the window
        step(1, 1, 0, 0);
        step(1, 1, 0, 0);
        for (int j = 2; j < MA; j++) step(1, 0, 0, 0);
        step(1, 0, 0, 1);
        check("R12 ack at window edge", m_ack, 1);
        for (int j = MA + 1; j <= 2 * MA; j++) begin
            step(1, 0, 0, 0);
            check("R12 restarted window", m_err, 0);
        end
        step(1, 0, 0, 0);
        check("R12 second window expires", m_err, 1);
        step(0, 0, 0, 0);

        // R9 / R11 late ack after abort
        step(1, 1, 0, 0);
        step(0, 0, 0, 1);
        check("R9 late ack blocked", m_ack, 0);
        step(1, 0, 0, 1);
        check("R11 late ack in new cycle blocked", m_ack, 0);
        for (int j = 0; j < MA + 3; j++) begin
            step(1, 0, 0, 0);
            check("R11 no timeout without open request", m_err, 0);
        end
        step(0, 0, 0, 0);

        // both limits expire on the same edge
        step(1, 1, 0, 0);
        for (int j = 1; j <= MA; j++) begin
            step(1, (j > MA - MS), (j > MA - MS), 0);
            check("R3 R4 coincident no early error", m_err, 0);
        end
        step(1, 1, 1, 0);
        check("R3 R4 coincident error", m_err, 1);
        check("R10 coincident no ack", m_ack, 0);
        step(0, 0, 0, 0);

        // randomized mix against the model
        rc = 1;
        for (int i = 0; i < 4000; i++) begin
            if (rc) rc = ($urandom % 50) != 0;
            else    rc = ($urandom % 3) == 0;
            step(rc, rc && ($urandom % 2 == 0) && (mo_open < 10),
                 ($urandom % 3) == 0, ($urandom % 5) == 0);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule